// File: doc/BRIEF.md
# Single-Entry Store Buffer with Load Overlap Replay

This block arbitrates one local data-memory port between the two stages of a CPU load/store path. Loads request the port one stage earlier than stores. A store in the later stage and a load in the earlier stage can therefore arrive in the same cycle. When that happens the load gets the port and the store is parked in a one-entry buffer. The parked store is written out on the next store or on the first cycle with no memory access. Stores to bus-attached memory skip the buffer and go out on a separate bus write channel in the same cycle.

Every load is described by up to two sub-accesses. Each sub-access is a word address with a byte mask. A half-word-aligned word load that runs past the end of a circular buffer is split in two. Its second half wraps to the bottom of the buffer. Each sub-access is checked against the parked store and against a store arriving in the same cycle. If any requested byte matches a byte those stores hold, the load is cancelled and the older store is written in that same cycle. The block then stalls the pipeline for one cycle and replays the saved load.

Top module: `store_bypass_buffer`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_en, ld_cancel, stall and bus_we are all low.
- R2: The store size code is 0 for a byte, 1 for a half-word and 2 for a word. A lone local store with an empty buffer and no load is written to the port in the same cycle. mem_addr is the byte address divided by 4. mem_be is 0001, 0011 or 1111 shifted left by the address low two bits, and mem_wdata holds the store data shifted left by 8 times those bits.
- R3: A local store and a non-overlapping load in the same cycle, with the buffer empty, give the port to the load as a read (mem_we low). The store enters the buffer.
- R4: A cycle with no load and no local store writes any parked store to the port, with its own word address, byte enables and lane-shifted data.
- R5: A local store arriving with the buffer full and no load writes the parked store to the port. The new store takes its place in the buffer.
- R6: A store with st_local low appears on bus_we, bus_addr, bus_be and bus_wdata in the same cycle. It never reaches the memory port.
- R7: The load is cancelled (ld_cancel high) if any byte of either sub-access is held by the parked store or by a local store arriving in the same cycle. In that same cycle the port writes the older of those stores.
- R8: A local store and a load in the same cycle with the buffer already full cancel the load even when no bytes overlap. The parked store is written and the new store enters the buffer.
- R9: In the cycle after ld_cancel, stall is high and the port carries the saved load again, with the same sub-access addresses and masks. All store and load inputs are ignored in a stall cycle.
- R10: Every load that the port serves returns, in each masked byte of both sub-accesses, the value a memory updated strictly in program order would hold. This holds for circular buffers based at low address nibble 0x0 or 0x8, of odd or even word counts, with a store of any size at any offset.
- R11: A load-only cycle that does not overlap the parked store reads the port and leaves the buffer untouched. The store is still written out on a later idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request from the later stage |
| st_local | input | 1 | Store targets local memory (1) or the bus (0) |
| st_addr | input | AW | Store byte address |
| st_size | input | 2 | 0 byte, 1 half-word, 2 word |
| st_data | input | DW | Store data, right-justified |
| ld_valid | input | 1 | Load request from the earlier stage |
| ld_a_word | input | AW-2 | First sub-access word address |
| ld_a_be | input | DW/8 | First sub-access byte mask |
| ld_b_en | input | 1 | Second (wrapped) sub-access present |
| ld_b_word | input | AW-2 | Second sub-access word address |
| ld_b_be | input | DW/8 | Second sub-access byte mask |
| ld_cancel | output | 1 | Load cancelled this cycle, replay follows |
| stall | output | 1 | Replay cycle; inputs ignored |
| mem_en | output | 1 | Port access this cycle |
| mem_we | output | 1 | Port access is a write |
| mem_addr | output | AW-2 | Port word address (write or first read lane) |
| mem_be | output | DW/8 | Port byte enables |
| mem_wdata | output | DW | Port write data |
| mem_b_en | output | 1 | Second read lane active |
| mem_b_addr | output | AW-2 | Second read lane word address |
| mem_b_be | output | DW/8 | Second read lane byte mask |
| bus_we | output | 1 | Bus store strobe |
| bus_addr | output | AW | Bus store byte address |
| bus_be | output | DW/8 | Bus store byte enables |
| bus_wdata | output | DW | Bus store lane-shifted data |

## Verification
On every cycle the assertions check that a cancel comes with a port write and has a load behind it. They also check that a stall follows every cancel and only a cancel, that the first replay reissues the saved descriptor, and that bus stores leave on the bus and nowhere else. Whether the overlap test is right, whether both halves of a wrapped load are covered, and whether the drain order keeps memory consistent cannot be seen in any one cycle. The bench shows these by checking every served read against a byte-wise program-order memory. It sweeps circular bases, sizes and store offsets and finishes with a full memory compare.

// File: rtl/store_bypass_buffer.sv
module store_bypass_buffer #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        st_valid,
  input  logic                        st_local,
  input  logic [AW-1:0]               st_addr,
  input  logic [1:0]                  st_size,
  input  logic [DW-1:0]               st_data,
  input  logic                        ld_valid,
  input  logic [AW-$clog2(DW/8)-1:0]  ld_a_word,
  input  logic [DW/8-1:0]             ld_a_be,
  input  logic                        ld_b_en,
  input  logic [AW-$clog2(DW/8)-1:0]  ld_b_word,
  input  logic [DW/8-1:0]             ld_b_be,
  output logic                        ld_cancel,
  output logic                        stall,
  output logic                        mem_en,
  output logic                        mem_we,
  output logic [AW-$clog2(DW/8)-1:0]  mem_addr,
  output logic [DW/8-1:0]             mem_be,
  output logic [DW-1:0]               mem_wdata,
  output logic                        mem_b_en,
  output logic [AW-$clog2(DW/8)-1:0]  mem_b_addr,
  output logic [DW/8-1:0]             mem_b_be,
  output logic                        bus_we,
  output logic [AW-1:0]               bus_addr,
  output logic [DW/8-1:0]             bus_be,
  output logic [DW-1:0]               bus_wdata
);
  localparam int NB = DW / 8;
  localparam int OW = $clog2(NB);
  localparam int WW = AW - OW;

  logic          bv;
  logic [WW-1:0] bw;
  logic [NB-1:0] bbe;
  logic [DW-1:0] bdat;

  logic          rp;
  logic [WW-1:0] rp_aw, rp_bw;
  logic [NB-1:0] rp_abe, rp_bbe;
  logic          rp_ben;

  wire [OW-1:0] st_off  = st_addr[OW-1:0];
  wire [WW-1:0] st_word = st_addr[AW-1:OW];
  logic [NB-1:0] st_mask, st_be;
  logic [DW-1:0] st_wd;

  always_comb begin
    case (st_size)
      2'd0:    st_mask = NB'(1);
      2'd1:    st_mask = NB'(3);
      default: st_mask = '1;
    endcase
    st_be = st_mask << st_off;
    st_wd = st_data << {st_off, 3'b000};
  end

  wire          el_v   = rp | ld_valid;
  wire [WW-1:0] el_aw  = rp ? rp_aw  : ld_a_word;
  wire [NB-1:0] el_abe = rp ? rp_abe : ld_a_be;
  wire          el_ben = rp ? rp_ben : ld_b_en;
  wire [WW-1:0] el_bw  = rp ? rp_bw  : ld_b_word;
  wire [NB-1:0] el_bbe = rp ? rp_bbe : ld_b_be;

  wire es     = !rp && st_valid && st_local;
  wire bus_st = !rp && st_valid && !st_local;

  function automatic logic overlap(input logic [WW-1:0] lw, input logic [NB-1:0] lm,
                                   input logic [WW-1:0] sw, input logic [NB-1:0] sm);
    return (lw == sw) && |(lm & sm);
  endfunction

  wire hit_b = bv && (overlap(el_aw, el_abe, bw, bbe) ||
                      (el_ben && overlap(el_bw, el_bbe, bw, bbe)));
  wire hit_s = es && (overlap(el_aw, el_abe, st_word, st_be) ||
                      (el_ben && overlap(el_bw, el_bbe, st_word, st_be)));

  wire cancel   = el_v && (hit_b || hit_s || (es && bv));
  wire read     = el_v && !cancel;
  wire drain_b  = bv && (cancel || !el_v);
  wire direct_s = es && !bv && (cancel || !el_v);
  wire capture  = es && !direct_s;

  always_comb begin
    mem_en = 1'b0;
    mem_we = 1'b0;
    mem_addr = '0;
    mem_be = '0;
    mem_wdata = '0;
    mem_b_en = 1'b0;
    mem_b_addr = '0;
    mem_b_be = '0;
    if (drain_b) begin
      mem_en = 1'b1;
      mem_we = 1'b1;
      mem_addr = bw;
      mem_be = bbe;
      mem_wdata = bdat;
    end else if (direct_s) begin
      mem_en = 1'b1;
      mem_we = 1'b1;
      mem_addr = st_word;
      mem_be = st_be;
      mem_wdata = st_wd;
    end else if (read) begin
      mem_en = 1'b1;
      mem_addr = el_aw;
      mem_be = el_abe;
      mem_b_en = el_ben;
      mem_b_addr = el_ben ? el_bw : '0;
      mem_b_be = el_ben ? el_bbe : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bv <= 1'b0;
      bw <= '0;
      bbe <= '0;
      bdat <= '0;
    end else if (capture) begin
      bv <= 1'b1;
      bw <= st_word;
      bbe <= st_be;
      bdat <= st_wd;
    end else if (drain_b) begin
      bv <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp <= 1'b0;
      rp_aw <= '0;
      rp_abe <= '0;
      rp_ben <= 1'b0;
      rp_bw <= '0;
      rp_bbe <= '0;
    end else begin
      rp <= cancel;
      if (cancel) begin
        rp_aw <= el_aw;
        rp_abe <= el_abe;
        rp_ben <= el_ben;
        rp_bw <= el_bw;
        rp_bbe <= el_bbe;
      end
    end
  end

  assign ld_cancel = cancel;
  assign stall     = rp;
  assign bus_we    = bus_st;
  assign bus_addr  = bus_st ? st_addr : '0;
  assign bus_be    = bus_st ? st_be : '0;
  assign bus_wdata = bus_st ? st_wd : '0;
endmodule

// File: rtl/store_bypass_buffer_chk.sv
module store_bypass_buffer_chk #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       st_valid,
  input logic                       st_local,
  input logic                       ld_valid,
  input logic [AW-$clog2(DW/8)-1:0] ld_a_word,
  input logic [DW/8-1:0]            ld_a_be,
  input logic                       ld_cancel,
  input logic                       stall,
  input logic                       mem_en,
  input logic                       mem_we,
  input logic [AW-$clog2(DW/8)-1:0] mem_addr,
  input logic [DW/8-1:0]            mem_be,
  input logic                       bus_we
);
  AST_CANCEL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cancel |-> (mem_en && mem_we)); // R7
  AST_CANCEL_HAS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cancel |-> (ld_valid || stall)); // R7
  AST_REPLAY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cancel |=> stall); // R9
  AST_STALL_ONLY_AFTER_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> $past(ld_cancel)); // R9
  AST_REPLAY_SAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !ld_cancel && !$past(stall)) |->
      (mem_en && !mem_we && mem_addr == $past(ld_a_word) && mem_be == $past(ld_a_be))); // R9
  AST_BUS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_local && !stall) |-> bus_we); // R6
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (st_valid && !st_local && !stall)); // R6
endmodule

bind store_bypass_buffer store_bypass_buffer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_local(st_local),
  .ld_valid(ld_valid), .ld_a_word(ld_a_word), .ld_a_be(ld_a_be),
  .ld_cancel(ld_cancel), .stall(stall), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be), .bus_we(bus_we)
);

// File: tb/sim_store_bypass_buffer.sv
`timescale 1ns/100ps
module sim_store_bypass_buffer;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NB = 4;
  localparam int WW = 8;
  localparam int MB = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic st_valid = 0, st_local = 0;
  logic [AW-1:0] st_addr = '0;
  logic [1:0] st_size = '0;
  logic [DW-1:0] st_data = '0;
  logic ld_valid = 0, ld_b_en = 0;
  logic [WW-1:0] ld_a_word = '0, ld_b_word = '0;
  logic [NB-1:0] ld_a_be = '0, ld_b_be = '0;
  logic ld_cancel, stall, mem_en, mem_we, mem_b_en, bus_we;
  logic [WW-1:0] mem_addr, mem_b_addr;
  logic [NB-1:0] mem_be, mem_b_be, bus_be;
  logic [DW-1:0] mem_wdata, bus_wdata;
  logic [AW-1:0] bus_addr;

  store_bypass_buffer #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_local(st_local),
    .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
    .ld_valid(ld_valid), .ld_a_word(ld_a_word), .ld_a_be(ld_a_be),
    .ld_b_en(ld_b_en), .ld_b_word(ld_b_word), .ld_b_be(ld_b_be),
    .ld_cancel(ld_cancel), .stall(stall), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_b_en(mem_b_en), .mem_b_addr(mem_b_addr), .mem_b_be(mem_b_be),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata)
  );

  logic [7:0] arch [MB];
  logic [7:0] act  [MB];
  int n_chk = 0, n_fail = 0, issued = 0, granted = 0;
  bit finished = 0;

  logic [WW-1:0] lda_w, ldb_w;
  logic [NB-1:0] lda_m, ldb_m;
  logic ldb_e;

  logic c_cancel, c_stall, c_en, c_we, c_bus;
  logic [WW-1:0] c_addr;
  logic [NB-1:0] c_be, c_bbe;
  logic [DW-1:0] c_wd, c_bwd;
  logic [AW-1:0] c_baddr;

  task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic set_plain(input int addr);
    lda_w = WW'(addr >> 2); lda_m = 4'hF; ldb_e = 0; ldb_w = '0; ldb_m = '0;
  endtask

  task automatic set_circ(input int base, input int nb, input int idx);
    int a, w0;
    lda_m = '0; ldb_m = '0; ldb_e = 0; ldb_w = '0;
    w0 = (base + idx % nb) >> 2;
    lda_w = WW'(w0);
    for (int k = 0; k < 4; k++) begin
      a = base + (idx + k) % nb;
      if ((a >> 2) == w0) lda_m[a & 3] = 1'b1;
      else begin ldb_e = 1; ldb_w = WW'(a >> 2); ldb_m[a & 3] = 1'b1; end
    end
  endtask

  task automatic sample();
    logic [31:0] ra, ea;
    c_cancel = ld_cancel; c_stall = stall; c_en = mem_en; c_we = mem_we;
    c_addr = mem_addr; c_be = mem_be; c_wd = mem_wdata; c_bus = bus_we;
    c_bbe = bus_be; c_bwd = bus_wdata; c_baddr = bus_addr;
    if (!stall && st_valid && st_local) begin
      for (int k = 0; k < (st_size == 0 ? 1 : st_size == 1 ? 2 : 4); k++)
        arch[int'(st_addr) + k] = st_data[8*k +: 8];
    end
    if (!stall && ld_valid) issued++;
    if (mem_en && mem_we) begin
      for (int j = 0; j < NB; j++)
        if (mem_be[j]) act[int'(mem_addr)*4 + j] = mem_wdata[8*j +: 8];
    end
    if (mem_en && !mem_we) begin
      granted++;
      ra = '0; ea = '0;
      for (int j = 0; j < NB; j++)
        if (mem_be[j]) begin ra[8*j +: 8] = act[int'(mem_addr)*4 + j]; ea[8*j +: 8] = arch[int'(mem_addr)*4 + j]; end
      chk(ra == ea, "R10 lane A read data", 64'(ra), 64'(ea));
      if (mem_b_en) begin
        ra = '0; ea = '0;
        for (int j = 0; j < NB; j++)
          if (mem_b_be[j]) begin ra[8*j +: 8] = act[int'(mem_b_addr)*4 + j]; ea[8*j +: 8] = arch[int'(mem_b_addr)*4 + j]; end
        chk(ra == ea, "R10 wrapped lane B read data", 64'(ra), 64'(ea));
      end
    end
  endtask

  task automatic drive(input bit sv, input bit sl, input int sa, input logic [31:0] sd,
                       input int ssz, input bit lv);
    st_valid = sv; st_local = sl; st_addr = AW'(sa); st_data = sd; st_size = 2'(ssz);
    ld_valid = lv; ld_a_word = lda_w; ld_a_be = lda_m;
    ld_b_en = ldb_e; ld_b_word = ldb_w; ld_b_be = ldb_m;
  endtask

  task automatic go(input bit sv, input bit sl, input int sa, input logic [31:0] sd,
                    input int ssz, input bit lv);
    @(negedge clk);
    while (stall) begin
      drive(0, 0, 0, 0, 0, 0); #1; sample(); @(negedge clk);
    end
    drive(sv, sl, sa, sd, ssz, lv); #1; sample();
  endtask

  task automatic raw(input bit sv, input bit sl, input int sa, input logic [31:0] sd,
                     input int ssz, input bit lv);
    @(negedge clk); drive(sv, sl, sa, sd, ssz, lv); #1; sample();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) go(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    int nb, bad;
    int bases [4] = '{32'h100, 32'h188, 32'h200, 32'h2C8};
    for (int i = 0; i < MB; i++) begin arch[i] = 8'(i ^ 8'h5A); act[i] = 8'(i ^ 8'h5A); end
    set_plain(0);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(!mem_en && !ld_cancel && !stall && !bus_we, "R1 outputs in reset",
        {mem_en, ld_cancel, stall, bus_we}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    chk(!mem_en && !ld_cancel && !stall && !bus_we, "R1 outputs after reset",
        {mem_en, ld_cancel, stall, bus_we}, 0);

    go(1, 1, 'h010, 32'hA1B2C3D4, 2, 0);
    chk(c_en && c_we && c_addr == 4 && c_be == 4'hF && c_wd == 32'hA1B2C3D4,
        "R2 word store direct", {c_we, c_addr, c_be, c_wd}, {1'b1, 8'd4, 4'hF, 32'hA1B2C3D4});
    go(1, 1, 'h022, 32'h5566, 1, 0);
    chk(c_en && c_we && c_addr == 8 && c_be == 4'hC && c_wd == 32'h55660000,
        "R2 half store direct", {c_addr, c_be, c_wd}, {8'd8, 4'hC, 32'h55660000});

    set_plain('h030);
    go(1, 1, 'h041, 32'h77, 0, 1);
    chk(c_en && !c_we && !c_cancel && c_addr == 12, "R3 load bypasses store",
        {c_we, c_cancel, c_addr}, {1'b0, 1'b0, 8'd12});
    go(0, 0, 0, 0, 0, 1);
    chk(c_en && !c_we && !c_cancel && c_addr == 12, "R11 load-only keeps buffer",
        {c_we, c_cancel, c_addr}, {1'b0, 1'b0, 8'd12});
    go(0, 0, 0, 0, 0, 0);
    chk(c_en && c_we && c_addr == 16 && c_be == 4'h2 && c_wd == 32'h00007700,
        "R4 R11 idle drain", {c_addr, c_be, c_wd}, {8'd16, 4'h2, 32'h00007700});

    go(1, 1, 'h050, 32'h11223344, 2, 1);
    go(1, 1, 'h060, 32'h55667788, 2, 0);
    chk(c_en && c_we && c_addr == 20 && c_wd == 32'h11223344, "R5 next store drains buffer",
        {c_addr, c_wd}, {8'd20, 32'h11223344});
    go(0, 0, 0, 0, 0, 0);
    chk(c_en && c_we && c_addr == 24 && c_wd == 32'h55667788, "R5 new store was buffered",
        {c_addr, c_wd}, {8'd24, 32'h55667788});

    go(1, 0, 'h072, 32'hDEAD, 1, 0);
    chk(c_bus && c_baddr == 'h072 && c_bbe == 4'hC && c_bwd == 32'hDEAD0000 && !c_en,
        "R6 bus store bypasses port", {c_bus, c_baddr, c_bbe, c_bwd, c_en},
        {1'b1, 10'h072, 4'hC, 32'hDEAD0000, 1'b0});

    go(1, 1, 'h081, 32'hC3, 0, 1);
    set_plain('h080);
    go(0, 0, 0, 0, 0, 1);
    chk(c_cancel && c_en && c_we && c_addr == 32 && c_be == 4'h2, "R7 overlap with buffer cancels",
        {c_cancel, c_we, c_addr, c_be}, {1'b1, 1'b1, 8'd32, 4'h2});
    raw(0, 0, 0, 0, 0, 0);
    chk(c_stall && c_en && !c_we && c_addr == 32 && c_be == 4'hF, "R9 replay after cancel",
        {c_stall, c_we, c_addr, c_be}, {1'b1, 1'b0, 8'd32, 4'hF});

    set_plain('h0A0);
    go(1, 1, 'h0A2, 32'hBEEF, 1, 1);
    chk(c_cancel && c_we && c_addr == 40 && c_be == 4'hC, "R7 overlap with arriving store",
        {c_cancel, c_addr, c_be}, {1'b1, 8'd40, 4'hC});

    set_plain('h030);
    go(1, 1, 'h0C0, 32'h0BADF00D, 2, 1);
    go(1, 1, 'h0D0, 32'hFEEDFACE, 2, 1);
    chk(c_cancel && c_we && c_addr == 48, "R8 full buffer store+load cancels",
        {c_cancel, c_addr}, {1'b1, 8'd48});
    raw(0, 0, 0, 0, 0, 0);
    chk(c_stall && c_en && !c_we && c_addr == 12, "R8 R9 replay reads load",
        {c_stall, c_we, c_addr}, {1'b1, 1'b0, 8'd12});
    go(0, 0, 0, 0, 0, 0);
    chk(c_we && c_addr == 52, "R8 new store drained later", c_addr, 52);

    set_plain('h030);
    go(1, 1, 'h0E3, 32'h99, 0, 1);
    set_plain('h0E0);
    go(0, 0, 0, 0, 0, 1);
    set_plain('h100);
    raw(1, 1, 'h0F0, 32'h12345678, 2, 1);
    chk(c_stall && !c_we && c_addr == 56, "R9 stall cycle serves replay only",
        {c_stall, c_we, c_addr}, {1'b1, 1'b0, 8'd56});
    idle(3);

    seed = 32'h1357_9BDF;
    foreach (bases[b]) begin
      for (int nw = 3; nw <= 6; nw++) begin
        nb = nw * 4;
        for (int o = 0; o < nb; o++) begin
          seed = seed * 32'd1664525 + 32'd1013904223;
          set_plain('h3F0);
          go(1, 1, bases[b] + o, seed, 0, 1);
          set_circ(bases[b], nb, nb - 2);
          go(0, 0, 0, 0, 0, 1);
          set_circ(bases[b], nb, nb - 2);
          go(1, 1, bases[b] + o, ~seed, 0, 1);
          if (o % 2 == 0) begin
            set_circ(bases[b], nb, (o + nb - 2) % nb);
            go(1, 1, bases[b] + o, seed ^ 32'h00FF00FF, 1, 1);
          end
          if (o % 4 == 0) begin
            set_circ(bases[b], nb, nb - 2);
            go(1, 1, bases[b] + o, seed + 32'h01010101, 2, 1);
            go(0, 0, 0, 0, 0, 1);
          end
        end
      end
    end
    idle(4);

    bad = 0;
    for (int i = 0; i < MB; i++) if (act[i] !== arch[i]) bad++;
    chk(bad == 0, "R10 final memory matches program order", bad, 0);
    chk(granted == issued, "R9 each issued load served once", granted, issued);
    finish_run();
  end
endmodule